// File: doc/BRIEF.md
# SM4 Byte Substitution through the AES Field

This block returns the SM4 substitution value of each input byte without holding the 256-entry SM4 table. Each byte goes through three steps. First, an affine map carries it from the SM4 field representation into the AES field. Second, the AES forward substitution is applied to it. Third, a second affine map carries the result back. Each affine map is built from two 16-entry nibble tables: one indexed by the low nibble, one indexed by the high nibble. The two table outputs are XORed.

The top module applies the same substitution to every byte lane of a word. The default word holds four lanes, which suits a 32-bit cipher round datapath. The logic is purely combinational, with no clock and no reset.

A parameter chooses how the middle AES step is built. It can compute the field inverse followed by the AES affine step. Or it can use a ROM, whose contents are computed when the design is elaborated.

Top module: `sm4_sbox_lanes`

## Requirements
- R1: For every byte x, the lane output equals the standard SM4 substitution of x. Examples: S(0x00)=0xD6, S(0x01)=0x90, S(0x02)=0xE9, S(0xFF)=0x48.
- R2: The entry map looks up the byte's low nibble in table LA = {01,07,72,74,E4,E2,97,91,57,51,24,22,B2,B4,C1,C7}. It looks up the high nibble in table HA = {00,A2,49,EB,09,AB,40,E2,12,B0,5B,F9,1B,B9,52,F0}. It XORs the two entries. Both tables are listed from index 0 upward.
- R3: The exit map works the same way. The low nibble indexes LB = {34,08,9D,A1,CE,F2,67,5B,82,BE,2B,17,78,44,D1,ED}. The high nibble indexes HB = {00,DC,AF,73,DD,01,72,AE,BF,63,10,CC,62,BE,CD,11}. The two entries are XORed. Both tables are listed from index 0 upward.
- R4: The middle step is the plain AES forward substitution, with no key or constant XOR. Its output never equals its input, and never equals the bitwise complement of its input.
- R5: The computed-inverse variant (USE_ROM=0) and the ROM variant (USE_ROM=1) give identical outputs for every input word.
- R6: Lane k occupies bits [8k+7:8k] of both word_in and word_out, for k from 0 to LANES-1.
- R7: Changing one input lane leaves the outputs of all other lanes unchanged.
- R8: There is no latency: the output follows a changed input within the same clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_in | input | 8*LANES (32) | Input bytes, lane k at bits [8k+7:8k] |
| word_out | output | 8*LANES (32) | Substituted bytes, same lane placement |

## Verification
Every result is combinational, so it is due in the same cycle as its stimulus. The bench drives each word on a rising clock edge and reads both variants on the falling edge that follows, half a period later. No check spans more than that half cycle. The lane-independence checks apply two words in successive cycles, and each pair is read only after the second word has settled.

// File: rtl/sm4_iso_pkg.sv
package sm4_iso_pkg;

   localparam int BYTE_W      = 8;
   localparam int NIB_W       = 4;
   localparam int NIB_ENTRIES = 1 << NIB_W;
   localparam int TBL_W       = NIB_ENTRIES * BYTE_W;
   localparam int FIELD_SIZE  = 1 << BYTE_W;
   localparam int ROM_W       = FIELD_SIZE * BYTE_W;

   // nibble tables, entry i at bits [8i+7:8i]
   localparam logic [TBL_W-1:0] ENTRY_LO_TBL = 128'hC7C1B4B2_22245157_9197E2E4_74720701;
   localparam logic [TBL_W-1:0] ENTRY_HI_TBL = 128'hF052B91B_F95BB012_E240AB09_EB49A200;
   localparam logic [TBL_W-1:0] EXIT_LO_TBL  = 128'hEDD14478_172BBE82_5B67F2CE_A19D0834;
   localparam logic [TBL_W-1:0] EXIT_HI_TBL  = 128'h11CDBE62_CC1063BF_AE7201DD_73AFDC00;

   typedef enum logic {MAP_ENTRY, MAP_EXIT} map_side_e;

   // product in GF(2^8) modulo x^8+x^4+x^3+x+1
   function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                                input logic [BYTE_W-1:0] b);
      logic [BYTE_W-1:0] acc;
      logic [BYTE_W-1:0] run;
      acc = '0;
      run = a;
      for (int i = 0; i < BYTE_W; i++) begin
         if (b[i]) acc = acc ^ run;
         run = {run[BYTE_W-2:0], 1'b0} ^ (run[BYTE_W-1] ? 8'h1B : 8'h00);
      end
      return acc;
   endfunction

   // inverse as a^254 by repeated squaring; zero maps to zero
   function automatic logic [BYTE_W-1:0] gf_inv(input logic [BYTE_W-1:0] a);
      logic [BYTE_W-1:0] sq;
      logic [BYTE_W-1:0] prod;
      sq   = a;
      prod = 8'h01;
      for (int i = 1; i < BYTE_W; i++) begin
         sq   = gf_mul(sq, sq);
         prod = gf_mul(prod, sq);
      end
      return prod;
   endfunction

   function automatic logic [BYTE_W-1:0] rotl8(input logic [BYTE_W-1:0] v, input int n);
      return (v << n) | (v >> (BYTE_W - n));
   endfunction

   function automatic logic [BYTE_W-1:0] aes_affine(input logic [BYTE_W-1:0] b);
      return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
   endfunction

   function automatic logic [BYTE_W-1:0] aes_sub(input logic [BYTE_W-1:0] b);
      return aes_affine(gf_inv(b));
   endfunction

   function automatic logic [ROM_W-1:0] build_aes_rom();
      logic [ROM_W-1:0] rom;
      rom = '0;
      for (int i = 0; i < FIELD_SIZE; i++) rom[i*BYTE_W +: BYTE_W] = aes_sub(i[BYTE_W-1:0]);
      return rom;
   endfunction

endpackage

// File: rtl/nib_lut.sv
module nib_lut #(
   parameter int NIB_W = 4,
   parameter int OUT_W = 8,
   parameter logic [(1<<NIB_W)*OUT_W-1:0] TABLE = '0
) (
   input  logic [NIB_W-1:0] idx,
   output logic [OUT_W-1:0] val
);
   localparam int ENTRIES = 1 << NIB_W;

   logic [OUT_W-1:0] entry [ENTRIES];

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
         assign entry[e] = TABLE[e*OUT_W +: OUT_W];
      end
   endgenerate

   assign val = entry[idx];
endmodule

// File: rtl/iso_affine_map.sv
module iso_affine_map
   import sm4_iso_pkg::*;
#(
   parameter map_side_e SIDE = MAP_ENTRY
) (
   input  logic [BYTE_W-1:0] map_in,
   output logic [BYTE_W-1:0] map_out
);
   localparam logic [TBL_W-1:0] LO_T = (SIDE == MAP_ENTRY) ? ENTRY_LO_TBL : EXIT_LO_TBL;
   localparam logic [TBL_W-1:0] HI_T = (SIDE == MAP_ENTRY) ? ENTRY_HI_TBL : EXIT_HI_TBL;
   localparam logic [BYTE_W-1:0] ZERO_IMAGE = LO_T[BYTE_W-1:0] ^ HI_T[BYTE_W-1:0];

   logic [BYTE_W-1:0] lo_part;
   logic [BYTE_W-1:0] hi_part;

   nib_lut #(.NIB_W(NIB_W), .OUT_W(BYTE_W), .TABLE(LO_T)) i_lo_lut (
      .idx (map_in[NIB_W-1:0]),
      .val (lo_part)
   );

   nib_lut #(.NIB_W(NIB_W), .OUT_W(BYTE_W), .TABLE(HI_T)) i_hi_lut (
      .idx (map_in[BYTE_W-1:NIB_W]),
      .val (hi_part)
   );

   assign map_out = lo_part ^ hi_part;

   // the map is a bijection, so only a zero input may land on the image of zero
   always_comb begin
      // R2
      // R3
      affine_bijective_chk: assert (map_in == '0 || map_out != ZERO_IMAGE)
         else $error("affine map collides with image of zero");
   end
endmodule

// File: rtl/aes_fwd_sub.sv
module aes_fwd_sub
   import sm4_iso_pkg::*;
#(
   parameter bit USE_ROM = 1'b0
) (
   input  logic [BYTE_W-1:0] sub_in,
   output logic [BYTE_W-1:0] sub_out
);
   generate
      if (USE_ROM) begin : g_rom
         localparam logic [ROM_W-1:0] ROM = build_aes_rom();
         assign sub_out = ROM[sub_in*BYTE_W +: BYTE_W];
      end else begin : g_calc
         logic [BYTE_W-1:0] inv_v;
         assign inv_v   = gf_inv(sub_in);
         assign sub_out = aes_affine(inv_v);
         always_comb begin
            // R4
            field_inverse_chk: assert ((sub_in == '0) ? (inv_v == '0) : (gf_mul(sub_in, inv_v) == 8'h01))
               else $error("field inverse wrong for %h", sub_in);
         end
      end
   endgenerate

   always_comb begin
      // R4
      no_fixed_point_chk: assert (sub_out != sub_in)
         else $error("substitution fixed point at %h", sub_in);
      // R4
      no_anti_fixed_point_chk: assert (sub_out != ~sub_in)
         else $error("substitution anti-fixed point at %h", sub_in);
   end
endmodule

// File: rtl/sm4_sbox_byte.sv
module sm4_sbox_byte
   import sm4_iso_pkg::*;
#(
   parameter bit USE_ROM = 1'b0
) (
   input  logic [BYTE_W-1:0] byte_in,
   output logic [BYTE_W-1:0] byte_out
);
   logic [BYTE_W-1:0] aes_dom;
   logic [BYTE_W-1:0] aes_img;

   iso_affine_map #(.SIDE(MAP_ENTRY)) i_entry_map (
      .map_in  (byte_in),
      .map_out (aes_dom)
   );

   aes_fwd_sub #(.USE_ROM(USE_ROM)) i_aes_sub (
      .sub_in  (aes_dom),
      .sub_out (aes_img)
   );

   iso_affine_map #(.SIDE(MAP_EXIT)) i_exit_map (
      .map_in  (aes_img),
      .map_out (byte_out)
   );
endmodule

// File: rtl/sm4_sbox_lanes.sv
module sm4_sbox_lanes
   import sm4_iso_pkg::*;
#(
   parameter int LANES   = 4,
   parameter bit USE_ROM = 1'b0
) (
   input  logic [LANES*8-1:0] word_in,
   output logic [LANES*8-1:0] word_out
);
   localparam int WORD_W = LANES * BYTE_W;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least one");
      end
      if (BYTE_W != 8) begin : g_bad_byte
         $error("lane width must be eight bits");
      end
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         sm4_sbox_byte #(.USE_ROM(USE_ROM)) i_sbox (
            .byte_in  (word_in[k*BYTE_W +: BYTE_W]),
            .byte_out (word_out[k*BYTE_W +: BYTE_W])
         );
      end
   endgenerate

   logic [WORD_W-1:0] unused_w;
   assign unused_w = '0;
endmodule

// File: tb/test_sm4_sbox_lanes.sv
module test_sm4_sbox_lanes;
   localparam int LANES = 4;
   localparam int W = LANES * 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [W-1:0] word_in;
   logic [W-1:0] out_calc;
   logic [W-1:0] out_rom;

   int checks = 0;
   int failures = 0;
   int unsigned seed = 32'd7351;

   int alog [256];
   int lg   [256];
   logic [7:0] ref_sbox [256];

   logic [7:0] la [16] = '{8'h01,8'h07,8'h72,8'h74,8'hE4,8'hE2,8'h97,8'h91,
                           8'h57,8'h51,8'h24,8'h22,8'hB2,8'hB4,8'hC1,8'hC7};
   logic [7:0] ha [16] = '{8'h00,8'hA2,8'h49,8'hEB,8'h09,8'hAB,8'h40,8'hE2,
                           8'h12,8'hB0,8'h5B,8'hF9,8'h1B,8'hB9,8'h52,8'hF0};
   logic [7:0] lb [16] = '{8'h34,8'h08,8'h9D,8'hA1,8'hCE,8'hF2,8'h67,8'h5B,
                           8'h82,8'hBE,8'h2B,8'h17,8'h78,8'h44,8'hD1,8'hED};
   logic [7:0] hb [16] = '{8'h00,8'hDC,8'hAF,8'h73,8'hDD,8'h01,8'h72,8'hAE,
                           8'hBF,8'h63,8'h10,8'hCC,8'h62,8'hBE,8'hCD,8'h11};

   sm4_sbox_lanes #(.LANES(LANES), .USE_ROM(1'b0)) i_sm4_sbox_lanes (
      .word_in  (word_in),
      .word_out (out_calc)
   );

   sm4_sbox_lanes #(.LANES(LANES), .USE_ROM(1'b1)) i_sm4_sbox_lanes_rom (
      .word_in  (word_in),
      .word_out (out_rom)
   );

   function automatic logic [7:0] rl(logic [7:0] v, int n);
      return (v << n) | (v >> (8 - n));
   endfunction

   // AES substitution from log/antilog tables (generator 3)
   function automatic logic [7:0] ref_aes(logic [7:0] x);
      logic [7:0] inv;
      inv = (x == 0) ? 8'h00 : 8'(alog[(255 - lg[x]) % 255]);
      return inv ^ rl(inv,1) ^ rl(inv,2) ^ rl(inv,3) ^ rl(inv,4) ^ 8'h63;
   endfunction

   function automatic logic [7:0] ref_sm4(logic [7:0] x);
      logic [7:0] a, s;
      a = la[x[3:0]] ^ ha[x[7:4]];          // R2
      s = ref_aes(a);                        // R4
      return lb[s[3:0]] ^ hb[s[7:4]];        // R3
   endfunction

   task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic apply(logic [W-1:0] w);
      @(posedge clk);
      word_in = w;
      @(negedge clk);
   endtask

   task automatic check_word(string req, logic [W-1:0] w);
      for (int k = 0; k < LANES; k++) begin
         chk(req, out_calc[k*8 +: 8], ref_sbox[w[k*8 +: 8]]);
         chk("R5", out_rom[k*8 +: 8], out_calc[k*8 +: 8]);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int g;
      g = 1;
      for (int i = 0; i < 255; i++) begin
         alog[i] = g;
         lg[g]   = i;
         g = g ^ (((g << 1) ^ ((g & 8'h80) != 0 ? 32'h11B : 32'h0)) & 8'hFF);
      end
      lg[0] = 0;
      for (int i = 0; i < 256; i++) ref_sbox[i] = ref_sm4(8'(i));
      word_in = '0;

      // R8 and idle state: an all-zero word settles at once
      apply('0);
      check_word("R8", '0);

      // R1 known values
      apply(32'hFF02_0100);
      chk("R1", out_calc[7:0],   8'hD6);
      chk("R1", out_calc[15:8],  8'h90);
      chk("R1", out_calc[23:16], 8'hE9);
      chk("R1", out_calc[31:24], 8'h48);

      // R6 lane placement: marker in one lane, zero elsewhere
      for (int k = 0; k < LANES; k++) begin
         logic [W-1:0] w;
         w = '0;
         w[k*8 +: 8] = 8'h01;
         apply(w);
         for (int j = 0; j < LANES; j++)
            chk("R6", out_calc[j*8 +: 8], (j == k) ? 8'h90 : 8'hD6);
      end

      // R1 full sweep, rotating the swept byte across lanes
      for (int v = 0; v < 256; v++) begin
         logic [W-1:0] w;
         w = $urandom(seed + v);
         w[(v % LANES)*8 +: 8] = 8'(v);
         apply(w);
         check_word("R1", w);
      end

      // R5 random words compared across both variants
      for (int n = 0; n < 200; n++) begin
         logic [W-1:0] w;
         w = $urandom();
         apply(w);
         check_word("R5", w);
      end

      // R7 lane independence
      for (int n = 0; n < 40; n++) begin
         logic [W-1:0] w0, w1, o0;
         int k;
         w0 = $urandom();
         k  = n % LANES;
         apply(w0);
         o0 = out_calc;
         w1 = w0;
         w1[k*8 +: 8] = w0[k*8 +: 8] ^ 8'(1 + ($urandom() % 255));
         apply(w1);
         for (int j = 0; j < LANES; j++)
            if (j != k) chk("R7", out_calc[j*8 +: 8], o0[j*8 +: 8]);
            else        chk("R7", out_calc[j*8 +: 8], ref_sbox[w1[j*8 +: 8]]);
      end

      finish_run();
   end
endmodule